// File: doc/BRIEF.md
# Up/down counter with snapshot register

The block is a 4-bit up/down counter paired with a separately clocked output register. On each rising edge of the counter clock it can clear, parallel-load from a 4-bit data input, count up or down, or hold. The choice depends on an active-low clear, an active-low load and two active-low count enables that must both be low for counting. A second clock copies the live count into a snapshot register, so software-visible or downstream logic can sample a stable value while the counter keeps running.

A select input routes either the live count or the snapshot to the data bus. An active-low output enable models the three-state pins as an enable flag plus a data bus. An active-low carry flag marks the terminal count for the current direction, which lets several blocks be chained. A parameter picks decade counting (0 to 9) or binary counting (0 to 15). A second parameter picks whether the clear acts on the counter clock edge or at once.

Top module: `updn_snap_counter`

## Requirements
- R1: While `rst_n` is low, the counter and the snapshot register are both 0, independent of any clock.
- R2: On a rising `cnt_clk` edge with `clr_n`=1, `load_n`=1 and `en_p_n`=`en_t_n`=0, the counter goes up by one when `up_dn`=1 and down by one when `up_dn`=0.
- R3: On a rising `cnt_clk` edge with `clr_n`=1 and `load_n`=0, the counter takes the value of `din`, whatever the enables and direction.
- R4: With `clr_n`=1 and `load_n`=1, a `cnt_clk` edge leaves the counter unchanged when `en_p_n` or `en_t_n` is 1.
- R5: `clr_n`=0 forces the counter to 0 and overrides load and count. With `ASYNC_CLR`=0 this takes effect at the next rising `cnt_clk` edge. With `ASYNC_CLR`=1 it takes effect at once, without a clock.
- R6: A rising `reg_clk` edge copies the current counter value into the snapshot register. Later counter activity leaves the snapshot unchanged until the next `reg_clk` edge.
- R7: Counting wraps. In decade mode (`DECADE`=1), up from 9 gives 0 and down from 0 gives 9. In binary mode (`DECADE`=0), up from 15 gives 0 and down from 0 gives 15.
- R8: `rco_n` is combinational. It is 0 exactly when `en_t_n`=0 and the counter equals the terminal value for the current direction: 9 (decade) or 15 (binary) when `up_dn`=1, and 0 when `up_dn`=0. Otherwise it is 1.
- R9: With `oe_n`=0, `q_out` shows the live counter when `sel_reg`=0 and the snapshot when `sel_reg`=1.
- R10: With `oe_n`=1, `q_oe` is 0 and `q_out` is 0 for any value of the other inputs. With `oe_n`=0, `q_oe` is 1.
- R11: In decade mode, values 10 to 15 may be loaded. Counting up from 10 to 14 adds one and from 15 gives 0. Counting down from 10 to 15 subtracts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnt_clk | input | 1 | Counter clock, rising edge |
| reg_clk | input | 1 | Snapshot register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Active-low counter clear |
| load_n | input | 1 | Active-low parallel load |
| en_p_n | input | 1 | Active-low count enable, first |
| en_t_n | input | 1 | Active-low count enable, second; also gates the carry flag |
| up_dn | input | 1 | Direction: 1 up, 0 down |
| din | input | 4 | Parallel load data |
| sel_reg | input | 1 | Output source: 0 live counter, 1 snapshot |
| oe_n | input | 1 | Active-low output enable |
| q_out | output | 4 | Output data bus |
| q_oe | output | 1 | Output bus driven when 1 |
| rco_n | output | 1 | Active-low terminal-count carry |

## Verification
Two instances run side by side: a decade counter with clocked clear, and a binary counter with immediate clear. Every start value from 0 to 15 is loaded into both and then counted in both directions through more than one full period. This separates correct wrap points from off-by-one terminal values, and it shows how out-of-range decade values return to the legal range. The carry flag is swept over every value, direction and state of the carry enable. Clear is applied between edges, which separates the two clear variants. A snapshot is taken and the counter is then moved on, which shows the snapshot holding apart from the live count.

// File: rtl/upc_pkg.sv
package upc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } upc_op_e;
endpackage

// File: rtl/upc_next.sv
module upc_next
  import upc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] din,
  input  logic             up_dn,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p_n,
  input  logic             en_t_n,
  output upc_op_e          op,
  output logic [WIDTH-1:0] nxt,
  output logic             at_term
);
  localparam logic [WIDTH-1:0] TOP_V  = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO_V = '0;
  localparam logic [WIDTH-1:0] ONE_V  = WIDTH'(1);

  // priority: clear, load, count, hold
  always_comb begin
    if (!clr_n)                 op = OP_CLEAR;
    else if (!load_n)           op = OP_LOAD;
    else if (!en_p_n && !en_t_n) op = OP_COUNT;
    else                        op = OP_HOLD;
  end

  always_comb begin
    at_term = up_dn ? (cnt == TOP_V) : (cnt == ZERO_V);
  end

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = ZERO_V;
      OP_LOAD:  nxt = din;
      OP_COUNT: begin
        if (up_dn) nxt = (cnt == TOP_V)  ? ZERO_V : cnt + ONE_V;
        else       nxt = (cnt == ZERO_V) ? TOP_V  : cnt - ONE_V;
      end
      default:  nxt = cnt;
    endcase
  end
endmodule

// File: rtl/upc_core.sv
module upc_core
  import upc_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p_n,
  input  logic             en_t_n,
  input  logic             up_dn,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cnt,
  output logic             at_term
);
  localparam logic [WIDTH-1:0] TOP_V = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  upc_op_e          op;
  logic [WIDTH-1:0] nxt;
  logic             upd;

  upc_next #(.WIDTH(WIDTH), .DECADE(DECADE)) next_i (
    .cnt(cnt), .din(din), .up_dn(up_dn), .clr_n(clr_n), .load_n(load_n),
    .en_p_n(en_p_n), .en_t_n(en_t_n), .op(op), .nxt(nxt), .at_term(at_term)
  );

  always_comb upd = (op != OP_HOLD);

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!clr_n) cnt <= '0;
        else if (upd)    cnt <= nxt;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (upd) cnt <= nxt;
      end
    end
  endgenerate

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (cnt == '0));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (clr_n && !load_n) |=> (cnt == $past(din)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (clr_n && load_n && (en_p_n || en_t_n)) |=> (cnt == $past(cnt)));

  p_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (clr_n && load_n && !en_p_n && !en_t_n && up_dn && cnt == TOP_V) |=> (cnt == '0));

  p_wrap_dn_r7: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (clr_n && load_n && !en_p_n && !en_t_n && !up_dn && cnt == '0) |=> (cnt == TOP_V));
endmodule

// File: rtl/upc_snap.sv
module upc_snap #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cnt_in,
  output logic [WIDTH-1:0] snap
);
  logic [WIDTH-1:0] snap_nxt;

  always_comb snap_nxt = cnt_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap <= '0;
    else        snap <= snap_nxt;
  end

  p_snap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (snap == $past(cnt_in)));
endmodule

// File: rtl/updn_snap_counter.sv
module updn_snap_counter #(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             cnt_clk,
  input  logic             reg_clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p_n,
  input  logic             en_t_n,
  input  logic             up_dn,
  input  logic [WIDTH-1:0] din,
  input  logic             sel_reg,
  input  logic             oe_n,
  output logic [WIDTH-1:0] q_out,
  output logic             q_oe,
  output logic             rco_n
);
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] snap;
  logic             at_term;

  upc_core #(.WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)) core_i (
    .clk(cnt_clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .en_p_n(en_p_n), .en_t_n(en_t_n), .up_dn(up_dn), .din(din),
    .cnt(cnt), .at_term(at_term)
  );

  upc_snap #(.WIDTH(WIDTH)) snap_i (
    .clk(reg_clk), .rst_n(rst_n), .cnt_in(cnt), .snap(snap)
  );

  always_comb begin
    q_oe  = !oe_n;
    q_out = oe_n ? '0 : (sel_reg ? snap : cnt);
    rco_n = !(!en_t_n && at_term);
  end

  p_rco_gate_r8: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    !rco_n |-> !en_t_n);

  p_bus_idle_r10: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    !q_oe |-> (q_out == '0));
endmodule

// File: tb/updn_snap_counter_tb_top.sv
module updn_snap_counter_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = CLK_P / 2;

  logic       cnt_clk = 1'b0;
  logic       reg_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       clr_n   = 1'b1;
  logic       load_n  = 1'b1;
  logic       en_p_n  = 1'b1;
  logic       en_t_n  = 1'b1;
  logic       up_dn   = 1'b1;
  logic [3:0] din     = 4'd0;
  logic       sel_reg = 1'b0;
  logic       oe_n    = 1'b0;

  logic [3:0] q_d, q_b;
  logic       oe_d, oe_b, rco_d, rco_b;

  int errs = 0;
  int checks = 0;
  int md = 0, mb = 0, sd = 0, sb = 0;

  updn_snap_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) dut_i (
    .cnt_clk(cnt_clk), .reg_clk(reg_clk), .rst_n(rst_n), .clr_n(clr_n),
    .load_n(load_n), .en_p_n(en_p_n), .en_t_n(en_t_n), .up_dn(up_dn),
    .din(din), .sel_reg(sel_reg), .oe_n(oe_n),
    .q_out(q_d), .q_oe(oe_d), .rco_n(rco_d)
  );

  updn_snap_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) dut_b (
    .cnt_clk(cnt_clk), .reg_clk(reg_clk), .rst_n(rst_n), .clr_n(clr_n),
    .load_n(load_n), .en_p_n(en_p_n), .en_t_n(en_t_n), .up_dn(up_dn),
    .din(din), .sel_reg(sel_reg), .oe_n(oe_n),
    .q_out(q_b), .q_oe(oe_b), .rco_n(rco_b)
  );

  function automatic int nx(int c, int top, bit u, bit ld, bit ep, bit et, bit cl, int d);
    if (!cl)           return 0;
    else if (!ld)      return d;
    else if (ep || et) return c;
    else if (u)        return (c == top) ? 0 : (c + 1) % 16;
    else               return (c == 0) ? top : c - 1;
  endfunction

  function automatic bit rco_exp(int c, int top, bit u, bit et);
    return !(!et && (u ? (c == top) : (c == 0)));
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic cyc(bit u, bit ld, bit ep, bit et, bit cl, int d, string tag);
    up_dn = u; load_n = ld; en_p_n = ep; en_t_n = et; clr_n = cl; din = 4'(d);
    #1;
    chk({tag, " R8 carry dec"}, 8'(rco_d), 8'(rco_exp(md, 9, u, et)));
    chk({tag, " R8 carry bin"}, 8'(rco_b), 8'(rco_exp(mb, 15, u, et)));
    #(HALF - 1) cnt_clk = 1'b1;
    md = nx(md, 9, u, ld, ep, et, cl, d);
    mb = nx(mb, 15, u, ld, ep, et, cl, d);
    #HALF cnt_clk = 1'b0;
    #1;
    chk({tag, " dec"}, 8'(q_d), 8'(md));
    chk({tag, " bin"}, 8'(q_b), 8'(mb));
  endtask

  task automatic snap_pulse();
    #HALF reg_clk = 1'b1;
    sd = md; sb = mb;
    #HALF reg_clk = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_P);
    chk("R1 live dec", 8'(q_d), 8'd0);
    chk("R1 live bin", 8'(q_b), 8'd0);
    sel_reg = 1'b1; #1;
    chk("R1 snap dec", 8'(q_d), 8'd0);
    chk("R1 snap bin", 8'(q_b), 8'd0);
    sel_reg = 1'b0;
    chk("R10 enabled", 8'(oe_d), 8'd1);
    #(CLK_P) rst_n = 1'b1;
    #(CLK_P);

    // R3 load every value, with enables and direction varied
    for (int v = 0; v < 16; v++) cyc(v[0], 1'b0, v[1], v[2], 1'b1, v, "R3 load");

    // R2 and R7 up and down from every start value, beyond one period
    for (int v = 0; v < 16; v++) begin
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, v, "R3 preload");
      for (int k = 0; k < 18; k++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R2 R7 R11 up");
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, v, "R3 preload");
      for (int k = 0; k < 18; k++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R2 R7 R11 down");
    end

    // R4 either enable high holds
    for (int e = 1; e < 4; e++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5, "R3 preload");
      for (int k = 0; k < 3; k++) cyc(k[0], 1'b1, e[0], e[1], 1'b1, 0, "R4 hold");
    end

    // R8 carry over every value, direction and enable
    for (int v = 0; v < 16; v++) begin
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, v, "R3 preload");
      for (int u = 0; u < 2; u++) begin
        for (int t = 0; t < 2; t++) begin
          up_dn = u[0]; en_t_n = t[0]; load_n = 1'b1; #1;
          chk("R8 sweep dec", 8'(rco_d), 8'(rco_exp(md, 9, u[0], t[0])));
          chk("R8 sweep bin", 8'(rco_b), 8'(rco_exp(mb, 15, u[0], t[0])));
        end
      end
    end

    // R5 clear overrides load and count
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6, "R3 preload");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11, "R5 clear over load");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 7, "R3 preload");
    clr_n = 1'b0; load_n = 1'b1; #2;
    mb = 0;
    chk("R5 async clear bin", 8'(q_b), 8'd0);
    chk("R5 sync clear waits dec", 8'(q_d), 8'd7);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R5 clear at edge");
    clr_n = 1'b1;

    // R6 and R9 snapshot independent of later counting
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3, "R3 preload");
    snap_pulse();
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 12, "R3 preload");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R2 step");
    sel_reg = 1'b1; #1;
    chk("R6 R9 snap dec", 8'(q_d), 8'(sd));
    chk("R6 R9 snap bin", 8'(q_b), 8'(sb));
    sel_reg = 1'b0; #1;
    chk("R9 live dec", 8'(q_d), 8'(md));
    chk("R9 live bin", 8'(q_b), 8'(mb));
    snap_pulse();
    sel_reg = 1'b1; #1;
    chk("R6 resnap dec", 8'(q_d), 8'(md));
    chk("R6 resnap bin", 8'(q_b), 8'(mb));

    // R10 output enable off
    oe_n = 1'b1;
    for (int s = 0; s < 2; s++) begin
      sel_reg = s[0]; #1;
      chk("R10 oe dec", 8'(oe_d), 8'd0);
      chk("R10 bus dec", 8'(q_d), 8'd0);
      chk("R10 oe bin", 8'(oe_b), 8'd0);
      chk("R10 bus bin", 8'(q_b), 8'd0);
    end
    oe_n = 1'b0; sel_reg = 1'b0; #1;
    chk("R10 restore", 8'(q_d), 8'(md));

    summary();
    $finish;
  end
endmodule